// File: doc/BRIEF.md
# Single-Cycle Core with Post-Increment Load

This block is a single-cycle 32-bit processor core for a small load/store instruction subset. Every instruction is fetched, decoded and completed in one clock. The subset covers register-to-register arithmetic and logic, word load and store, branch-if-equal, and jump-to-register. It also has one combined instruction, the post-increment load. That instruction loads a word from a base register plus an offset. In the same cycle it advances the base register by one word.

The combined instruction relies on a second register-file write port. This port is fed by a fixed incrementer on the first read operand. Both write ports commit at the clock edge that ends the instruction, so the memory address is always formed from the old base value. A final multiplexer after the branch selection lets jump-to-register replace the next program counter with the first read operand.

The instruction store and the data store are internal word arrays. They are filled through a load port while reset is held. A debug port shows the program counter and gives one extra register read, so architectural state can be compared after each instruction.

Top module: `cpu_core`

## Requirements
- R1: While `rst` is high the program counter and every register read 0. A pulse on `loadEn` with `rst` high writes `loadData` to word `loadAddr`. It goes to the instruction store when `loadSel`=0 and to the data store when `loadSel`=1.
- R2: Opcode 0x00 with funct 0x20/0x22/0x24/0x25/0x2A performs add/sub/and/or/signed set-less-than on the registers in bits [25:21] and [20:16]. It writes the register in bits [15:11] and advances the PC by 4.
- R3: Opcode 0x23 loads the data word at byte address reg[25:21] + sign-extended bits [15:0] into register [20:16]. The word index is address bits [7:2].
- R4: Opcode 0x2B stores register [20:16] to the data word at reg[25:21] + sign-extended offset. No register changes.
- R5: Opcode 0x04 compares registers [25:21] and [20:16]. If they are equal, the next PC is PC+4 + (sign-extended offset << 2). Otherwise it is PC+4.
- R6: Opcode 0x00 with funct 0x08 sets the next PC to register [25:21] and writes no register.
- R7: Opcode 0x30 loads the word at reg[25:21] + sign-extended offset into register [20:16]. In the same cycle it writes reg[25:21] + 4 into register [25:21]. The address uses the base value from before the instruction.
- R8: When both write ports target the same register in one cycle, the incremented base value is stored.
- R9: Writes to register 0 are discarded, and register 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; the load port works only while high |
| loadEn | input | 1 | Write strobe of the preload port |
| loadSel | input | 1 | Preload target: 0 instruction store, 1 data store |
| loadAddr | input | 6 | Word index for the preload write |
| loadData | input | 32 | Word written by the preload port |
| dbgRegAddr | input | 5 | Register index for the debug read |
| dbgPc | output | 32 | Current program counter |
| dbgRegData | output | 32 | Contents of register `dbgRegAddr` (combinational) |

## Verification
The hardest situations to reach are these. One is a post-increment load whose destination is also its base register, so both write ports aim at one entry. Another is a chain of post-increment loads in which each one must address memory with the base from before its own increment. The stimulus program builds a base pointer with a plain load and then issues three back-to-back post-increment loads from it. The last of these names the base as its own destination. A fourth one targets register 0. A behavioural reference model steps the same program and compares the PC and all 32 registers after every clock, including across taken branches and a register jump that skip instructions.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int XLEN      = 32;
  localparam int REG_COUNT = 32;
  localparam int REG_AW    = $clog2(REG_COUNT);

  localparam logic [5:0] OP_RTYPE   = 6'h00;
  localparam logic [5:0] OP_BEQ     = 6'h04;
  localparam logic [5:0] OP_LOAD    = 6'h23;
  localparam logic [5:0] OP_STORE   = 6'h2B;
  localparam logic [5:0] OP_LOADINC = 6'h30;

  localparam logic [5:0] FN_JR  = 6'h08;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     regDst;    // destination from bits [15:11]
    logic     aluSrc;    // second operand is the immediate
    logic     memToReg;  // write-back from data store
    logic     regWrite;  // first write port enable
    logic     memRead;
    logic     memWrite;
    logic     branch;
    logic     incWrite;  // second write port enable (post-increment)
    logic     jumpReg;   // late PC mux selects read data 1
    alu_sel_e aluSel;
  } ctrl_t;
endpackage

// File: rtl/cpu_control.sv
module cpu_control
  import cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  logic [1:0] aluOp;

  // Main decoder
  always_comb begin
    ctrl          = '0;
    ctrl.aluSel   = ALU_ADD;
    aluOp         = 2'b00;
    case (opcode)
      OP_RTYPE: begin
        aluOp = 2'b10;
        if (funct == FN_JR) begin
          ctrl.jumpReg = 1'b1;
        end else begin
          ctrl.regDst   = 1'b1;
          ctrl.regWrite = 1'b1;
        end
      end
      OP_LOAD: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memToReg = 1'b1;
        ctrl.regWrite = 1'b1;
        ctrl.memRead  = 1'b1;
      end
      OP_LOADINC: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memToReg = 1'b1;
        ctrl.regWrite = 1'b1;
        ctrl.memRead  = 1'b1;
        ctrl.incWrite = 1'b1;
      end
      OP_STORE: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        aluOp       = 2'b01;
      end
      default: ;
    endcase

    // ALU control
    case (aluOp)
      2'b01: ctrl.aluSel = ALU_SUB;
      2'b10: begin
        case (funct)
          FN_SUB:  ctrl.aluSel = ALU_SUB;
          FN_AND:  ctrl.aluSel = ALU_AND;
          FN_OR:   ctrl.aluSel = ALU_OR;
          FN_SLT:  ctrl.aluSel = ALU_SLT;
          default: ctrl.aluSel = ALU_ADD;
        endcase
      end
      default: ctrl.aluSel = ALU_ADD;
    endcase
  end

  assert_single_action_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.memRead, ctrl.memWrite, ctrl.branch, ctrl.jumpReg}));

  assert_incwrite_shape_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl.incWrite |-> (ctrl.regWrite && ctrl.memRead && ctrl.memToReg && !ctrl.regDst));

  assert_jr_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl.jumpReg |-> !(ctrl.regWrite || ctrl.incWrite || ctrl.memWrite));
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  alu_sel_e         sel,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  always_comb begin
    case (sel)
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SLT: result = {{(WIDTH-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: result = opA + opB;
    endcase
  end
  assign zero = (result == '0);
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int WIDTH = 32,
  parameter int COUNT = 32,
  localparam int AW   = $clog2(COUNT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    rdAddrA,
  output logic [WIDTH-1:0] rdDataA,
  input  logic [AW-1:0]    rdAddrB,
  output logic [WIDTH-1:0] rdDataB,
  input  logic [AW-1:0]    rdAddrDbg,
  output logic [WIDTH-1:0] rdDataDbg,
  input  logic             wrEn1,
  input  logic [AW-1:0]    wrAddr1,
  input  logic [WIDTH-1:0] wrData1,
  input  logic             wrEn2,
  input  logic [AW-1:0]    wrAddr2,
  input  logic [WIDTH-1:0] wrData2
);
  logic [WIDTH-1:0] regs [COUNT];

  // Port 2 is written last so it wins a same-register collision
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < COUNT; i++) regs[i] <= '0;
    end else begin
      if (wrEn1 && wrAddr1 != '0) regs[wrAddr1] <= wrData1;
      if (wrEn2 && wrAddr2 != '0) regs[wrAddr2] <= wrData2;
    end
  end

  assign rdDataA   = (rdAddrA   == '0) ? '0 : regs[rdAddrA];
  assign rdDataB   = (rdAddrB   == '0) ? '0 : regs[rdAddrB];
  assign rdDataDbg = (rdAddrDbg == '0) ? '0 : regs[rdAddrDbg];

  assert_port1_commit_R3: assert property (@(posedge clk) disable iff (rst)
    (wrEn1 && wrAddr1 != '0 && !(wrEn2 && wrAddr2 == wrAddr1))
      |=> regs[$past(wrAddr1)] == $past(wrData1));

  assert_port2_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (wrEn2 && wrAddr2 != '0) |=> regs[$past(wrAddr2)] == $past(wrData2));
endmodule

// File: rtl/cpu_datapath.sv
module cpu_datapath
  import cpu_pkg::*;
#(
  parameter int XW        = 32,
  parameter int MEM_WORDS = 64,
  parameter int INC_STEP  = 4,
  localparam int MEM_AW   = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  output logic [5:0]        opcode,
  output logic [5:0]        funct,
  input  logic              loadEn,
  input  logic              loadSel,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [XW-1:0]     loadData,
  input  logic [REG_AW-1:0] dbgRegAddr,
  output logic [XW-1:0]     dbgPc,
  output logic [XW-1:0]     dbgRegData
);
  logic [XW-1:0] pc, pcPlus4, branchTarget, pcAfterBranch, pcNext;
  logic [XW-1:0] instr, immExt;
  logic [XW-1:0] rsData, rtData, aluB, aluRes, memData, writeData1, incSum;
  logic [REG_AW-1:0] rsAddr, rtAddr, rdAddr, writeAddr1;
  logic [MEM_AW-1:0] pcIdx, dataIdx;
  logic aluZero, takeBranch;

  logic [XW-1:0] imem [MEM_WORDS];
  logic [XW-1:0] dmem [MEM_WORDS];

  // Fetch and field split
  assign pcIdx  = pc[MEM_AW+1:2];
  assign instr  = imem[pcIdx];
  assign opcode = instr[31:26];
  assign rsAddr = instr[25:21];
  assign rtAddr = instr[20:16];
  assign rdAddr = instr[15:11];
  assign funct  = instr[5:0];
  assign immExt = {{(XW-16){instr[15]}}, instr[15:0]};

  // Register file with the post-increment port
  assign writeAddr1 = ctrl.regDst ? rdAddr : rtAddr;
  assign writeData1 = ctrl.memToReg ? memData : aluRes;
  assign incSum     = rsData + XW'(INC_STEP);

  cpu_regfile #(.WIDTH(XW), .COUNT(REG_COUNT)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .rdAddrA   (rsAddr),
    .rdDataA   (rsData),
    .rdAddrB   (rtAddr),
    .rdDataB   (rtData),
    .rdAddrDbg (dbgRegAddr),
    .rdDataDbg (dbgRegData),
    .wrEn1     (ctrl.regWrite),
    .wrAddr1   (writeAddr1),
    .wrData1   (writeData1),
    .wrEn2     (ctrl.incWrite),
    .wrAddr2   (rsAddr),
    .wrData2   (incSum)
  );

  // Execute
  assign aluB = ctrl.aluSrc ? immExt : rtData;

  cpu_alu #(.WIDTH(XW)) u_alu (
    .opA    (rsData),
    .opB    (aluB),
    .sel    (ctrl.aluSel),
    .result (aluRes),
    .zero   (aluZero)
  );

  // Data store and preload port
  assign dataIdx = aluRes[MEM_AW+1:2];
  assign memData = ctrl.memRead ? dmem[dataIdx] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      if (loadEn && loadSel)  dmem[loadAddr] <= loadData;
      if (loadEn && !loadSel) imem[loadAddr] <= loadData;
    end else if (ctrl.memWrite) begin
      dmem[dataIdx] <= rtData;
    end
  end

  // Next PC: branch mux, then the late register-jump mux
  assign pcPlus4       = pc + XW'(4);
  assign branchTarget  = pcPlus4 + {immExt[XW-3:0], 2'b00};
  assign takeBranch    = ctrl.branch & aluZero;
  assign pcAfterBranch = takeBranch ? branchTarget : pcPlus4;
  assign pcNext        = ctrl.jumpReg ? rsData : pcAfterBranch;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  assign dbgPc = pc;

  assert_pc_sequential_R2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jumpReg && !takeBranch) |=> pc == $past(pc) + XW'(4));

  assert_branch_target_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && rsData == rtData) |=>
      pc == $past(pc) + XW'(4) + {$past(immExt[XW-3:0]), 2'b00});

  assert_jr_target_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl.jumpReg |=> pc == $past(rsData));

  assert_store_commit_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl.memWrite |=> dmem[$past(dataIdx)] == $past(rtData));
endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int XW        = 32,
  parameter int MEM_WORDS = 64,
  localparam int MEM_AW   = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              loadSel,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [XW-1:0]     loadData,
  input  logic [REG_AW-1:0] dbgRegAddr,
  output logic [XW-1:0]     dbgPc,
  output logic [XW-1:0]     dbgRegData
);
  ctrl_t      ctrl;
  logic [5:0] opcode, funct;

  cpu_control u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  cpu_datapath #(.XW(XW), .MEM_WORDS(MEM_WORDS), .INC_STEP(4)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .opcode     (opcode),
    .funct      (funct),
    .loadEn     (loadEn),
    .loadSel    (loadSel),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .dbgRegAddr (dbgRegAddr),
    .dbgPc      (dbgPc),
    .dbgRegData (dbgRegData)
  );
endmodule

// File: tb/sim_cpu_core.sv
`timescale 1ns/1ps
module sim_cpu_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0;
  logic        loadSel = 1'b0;
  logic [5:0]  loadAddr = '0;
  logic [31:0] loadData = '0;
  logic [4:0]  dbgRegAddr = '0;
  logic [31:0] dbgPc, dbgRegData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cpu_core u0 (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadSel(loadSel),
    .loadAddr(loadAddr), .loadData(loadData),
    .dbgRegAddr(dbgRegAddr), .dbgPc(dbgPc), .dbgRegData(dbgRegData)
  );

  always #10 clk = ~clk;  // 50 MHz

  // Reference state
  logic [31:0] mImem [64];
  logic [31:0] mDmem [64];
  logic [31:0] mRegs [32];
  logic [31:0] mPc;
  string       lastTag;

  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic modelStep();
    logic [31:0] ins, a, b, imm, res, addr, nextPc;
    logic [5:0] op, fn;
    int s, t, d, w1, w2;
    logic [31:0] wd1, wd2;
    ins = mImem[mPc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    s = int'(ins[25:21]); t = int'(ins[20:16]); d = int'(ins[15:11]);
    imm = {{16{ins[15]}}, ins[15:0]};
    a = mRegs[s]; b = mRegs[t];
    nextPc = mPc + 4; w1 = -1; w2 = -1; wd1 = '0; wd2 = '0;
    addr = a + imm;
    lastTag = "R2";
    case (op)
      6'h00: begin
        if (fn == 6'h08) begin
          nextPc = a; lastTag = "R6";
        end else begin
          case (fn)
            6'h22: res = a - b;
            6'h24: res = a & b;
            6'h25: res = a | b;
            6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: res = a + b;
          endcase
          w1 = d; wd1 = res;
          if (d == 0) lastTag = "R9";
        end
      end
      6'h23: begin w1 = t; wd1 = mDmem[addr[7:2]]; lastTag = "R3"; end
      6'h2B: begin mDmem[addr[7:2]] = b; lastTag = "R4"; end
      6'h04: begin
        if (a == b) nextPc = mPc + 4 + (imm << 2);
        lastTag = "R5";
      end
      6'h30: begin
        w1 = t; wd1 = mDmem[addr[7:2]];
        w2 = s; wd2 = a + 4;
        lastTag = "R7";
        if (s == t) lastTag = "R8";
        if (s == 0 || t == 0) lastTag = "R9";
      end
      default: ;
    endcase
    if (w1 >= 0) mRegs[w1] = wd1;
    if (w2 >= 0) mRegs[w2] = wd2;
    mRegs[0] = '0;
    mPc = nextPc;
  endtask

  task automatic readReg(input int idx, output logic [31:0] val);
    dbgRegAddr = 5'(idx);
    #0.1;
    val = dbgRegData;
  endtask

  task automatic compareState(input string tag);
    logic [31:0] v;
    int bad;
    checks++;
    if (dbgPc !== mPc) begin
      errors++;
      $display("FAIL %s pc: actual %h expected %h", tag, dbgPc, mPc);
    end
    checks++;
    bad = -1;
    for (int i = 0; i < 32; i++) begin
      readReg(i, v);
      if (v !== mRegs[i] && bad < 0) begin
        bad = i;
        errors++;
        $display("FAIL %s reg%0d: actual %h expected %h", tag, i, v, mRegs[i]);
      end
    end
  endtask

  task automatic expectReg(input int idx, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    readReg(idx, v);
    checks++;
    if (v !== exp) begin
      errors++;
      $display("FAIL %s reg%0d: actual %h expected %h", tag, idx, v, exp);
    end
  endtask

  task automatic preload(input logic sel, input int addr, input logic [31:0] data);
    @(negedge clk);
    loadEn = 1'b1; loadSel = sel; loadAddr = 6'(addr); loadData = data;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mImem[i] = encI(6'h04, 0, 0, -1);  // self loop filler
      mDmem[i] = 32'h1000 + 32'(i * 7);
    end
    mDmem[0] = 32'd5; mDmem[1] = 32'd9; mDmem[2] = 32'd16; mDmem[3] = 32'd88;
    for (int i = 0; i < 32; i++) mRegs[i] = '0;
    mPc = '0;

    mImem[0]  = encI(6'h23, 0, 1, 0);
    mImem[1]  = encI(6'h23, 0, 2, 4);
    mImem[2]  = encR(1, 2, 3, 6'h20);
    mImem[3]  = encR(1, 2, 4, 6'h22);
    mImem[4]  = encR(1, 2, 5, 6'h24);
    mImem[5]  = encR(1, 2, 6, 6'h25);
    mImem[6]  = encR(4, 1, 7, 6'h2A);   // signed: -4 < 5
    mImem[7]  = encR(1, 4, 8, 6'h2A);
    mImem[8]  = encI(6'h23, 0, 9, 8);   // base pointer 16
    mImem[9]  = encI(6'h30, 9, 10, 0);
    mImem[10] = encI(6'h30, 9, 11, 4);
    mImem[11] = encI(6'h30, 9, 9, 0);   // same register on both ports
    mImem[12] = encI(6'h30, 0, 12, 0);  // base is register 0
    mImem[13] = encI(6'h2B, 0, 3, 40);
    mImem[14] = encI(6'h23, 0, 13, 40);
    mImem[15] = encI(6'h04, 1, 2, 5);   // not taken
    mImem[16] = encI(6'h04, 1, 1, 2);   // taken to word 19
    mImem[17] = encR(1, 1, 14, 6'h20);
    mImem[18] = encR(1, 1, 14, 6'h20);
    mImem[19] = encI(6'h23, 0, 15, 12); // 88
    mImem[20] = encR(15, 0, 0, 6'h08);  // jr to word 22
    mImem[21] = encR(1, 1, 16, 6'h20);
    mImem[22] = encR(1, 1, 0, 6'h20);   // write to register 0
    mImem[23] = encR(1, 1, 17, 6'h20);
    mImem[24] = encI(6'h04, 0, 0, -1);

    rst = 1'b1;
    for (int i = 0; i < 64; i++) preload(1'b0, i, mImem[i]);
    for (int i = 0; i < 64; i++) preload(1'b1, i, mDmem[i]);
    @(negedge clk);
    rst = 1'b0;
    #1;
    compareState("R1");
    for (int c = 0; c < 40; c++) begin
      modelStep();
      @(posedge clk);
      @(negedge clk);
      #1;
      compareState(lastTag);
    end

    expectReg(9,  32'd28,     "R8");
    expectReg(10, 32'h101C,   "R7");
    expectReg(11, 32'h102A,   "R7");
    expectReg(12, 32'd5,      "R9");
    expectReg(0,  32'd0,      "R9");
    expectReg(13, 32'd14,     "R4");
    expectReg(7,  32'd1,      "R2");
    expectReg(8,  32'd0,      "R2");
    expectReg(14, 32'd0,      "R5");
    expectReg(16, 32'd0,      "R6");
    expectReg(17, 32'd10,     "R3");
    checks++;
    if (dbgPc !== 32'd96) begin
      errors++;
      $display("FAIL R5 halt pc: actual %h expected %h", dbgPc, 32'd96);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule